// File: doc/BRIEF.md
# Dual-Mode Write-Only Control Register Port

This block is the control-register slave of a larger device. It holds four 8-bit configuration registers. A host can write them through one of two serial ports. One is a 3-wire port with an active-low select, a clock and a data input. The other is a two-wire bus with clock and data lines, where the slave pulls the data line low only to acknowledge. A static mode pin picks the port that listens. The other port is held idle. Neither port returns register contents, so the host cannot read the registers back.

Every serial input is brought into the system clock domain by a synchronizer chain, and edges are then detected on the synchronized copies. Both front ends turn a finished transfer into a single-cycle write strobe that goes to a shared register bank. Register 01h carries a self-initialize bit: writing it with a 1 puts every register back to its power-up value. The two-wire port sets its register pointer from the second byte of a transfer. It then writes any number of data bytes, moving the pointer on after each one.

Top module: `regport_top`

## Requirements
- R1: After reset the register outputs are reg0=89h, reg1=02h, reg2=0Fh and reg3=00h. Register n sits at regs_o[8n+7:8n].
- R2: With mode_tw=0, a 3-wire frame is collected while cs_n is low. Each bit is taken on a rising sck edge, MSB first, 16 bits in total. Frame bits [15:14] are the chip code and must be 11. Bit [13] is the write flag and must be 1. Bits [12:8] are the register address and bits [7:0] are the data. The write takes effect when cs_n rises.
- R3: A 3-wire frame whose chip code is not 11, whose write flag is 0, or whose bit count is not exactly 16 leaves every register unchanged.
- R4: The two-wire address byte is {001001, addr_pin, direction}. If the address matches and the direction is 0, the slave acknowledges by holding sda_pull_low high during the 9th clock. On any mismatch, or with direction 1, the slave does not acknowledge and ignores the bus until the next START.
- R5: The byte after the address is the register pointer. If its top three bits are not zero, the slave does not acknowledge it and ignores the bus until the next START.
- R6: Each two-wire data byte after the pointer is acknowledged and written at the pointer. The pointer then advances: 03h goes to 00h, 1Fh goes to 00h, and any other value goes up by one.
- R7: Writes to addresses 04h-1Fh change no register on either port. The two-wire port still acknowledges them.
- R8: Writing register 01h with bit 7 set puts all four registers back to their R1 values. The written byte itself is not stored.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP, bytes are ignored until a START. A repeated START begins a new address phase.
- R10: With mode_tw=0 the two-wire lines are ignored and SDA is never pulled. With mode_tw=1 the 3-wire port is ignored.
- R11: sda_pull_low changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_tw | input | 1 | Port select: 1 = two-wire, 0 = 3-wire |
| addr_pin | input | 1 | Selectable bit of the two-wire device address |
| cs_n | input | 1 | 3-wire select, active low |
| sck | input | 1 | 3-wire bit clock |
| sdi | input | 1 | 3-wire data |
| scl | input | 1 | Two-wire clock line |
| sda_in | input | 1 | Level seen on the two-wire data line |
| sda_pull_low | output | 1 | Pulls the open-drain data line low when 1 |
| regs_o | output | 32 | Four registers, register n at bits [8n+7:8n] |

## Verification
A 3-wire write lands four clock edges after cs_n rises: two synchronizer stages, the edge detector feeding the strobe register, then the bank. The bench therefore samples regs_o eight cycles after raising cs_n. On the two-wire side, the acknowledge rises three edges after SCL falls at the end of a byte. A data byte reaches the bank one edge after that. The bench reads the acknowledge in the middle of the 9th SCL high phase, twelve cycles after that fall, and reads the registers eight cycles after each STOP. All inputs change on falling clock edges, so the sample points cannot land on a synchronizer edge.

// File: rtl/regport_pkg.sv
package regport_pkg;

  localparam int unsigned REG_COUNT  = 4;
  localparam int unsigned REG_WIDTH  = 8;
  localparam int unsigned ADDR_WIDTH = 5;
  localparam int unsigned INIT_REG   = 1;
  localparam int unsigned INIT_BIT   = 7;
  localparam logic [5:0]  DEV_PREFIX = 6'b001001;

  typedef enum logic [2:0] {
    TW_IDLE,
    TW_ADDR,
    TW_PTR,
    TW_DATA,
    TW_SKIP
  } tw_state_e;

  // Power-up value of each register.
  function automatic logic [REG_WIDTH-1:0] reg_default(input int unsigned idx);
    case (idx)
      0:       return 8'h89;
      1:       return 8'h02;
      2:       return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  // Pointer step: wrap after the last implemented register, else count up.
  function automatic logic [ADDR_WIDTH-1:0] ptr_next(input logic [ADDR_WIDTH-1:0] p,
                                                    input int unsigned nreg);
    if (32'(p) == nreg - 1) return '0;
    return p + 1'b1;
  endfunction

  function automatic logic dev_match(input logic [7:0] b, input logic sel_bit);
    return (b[7:1] == {DEV_PREFIX, sel_bit}) && !b[0];
  endfunction

endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  for (genvar i = 0; i < W; i++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= {STAGES{RST_VAL[i]}};
        prev  <= RST_VAL[i];
      end else begin
        chain <= {chain[STAGES-2:0], d[i]};
        prev  <= chain[STAGES-1];
      end
    end

    assign q[i]    = chain[STAGES-1];
    assign rise[i] = chain[STAGES-1] & ~prev;
    assign fall[i] = ~chain[STAGES-1] & prev;
  end

endmodule

// File: rtl/regport_sw3.sv
module regport_sw3 #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned AW = regport_pkg::ADDR_WIDTH,
  parameter int unsigned DW = regport_pkg::REG_WIDTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cs_q,
  input  logic          cs_rise,
  input  logic          cs_fall,
  input  logic          sck_rise,
  input  logic          sdi_q,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  localparam int unsigned CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_SAT  = CW'(FRAME_BITS + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [CW-1:0]         bitcnt;
  logic                  frame_ok;

  // Header: two chip-code ones, then the write flag.
  assign frame_ok = (bitcnt == CNT_FULL) &&
                    (shreg[FRAME_BITS-1 -: 3] == 3'b111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bitcnt  <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (!en) begin
      shreg  <= '0;
      bitcnt <= '0;
      wr_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (cs_fall) begin
        bitcnt <= '0;
      end else if (!cs_q && sck_rise) begin
        shreg <= {shreg[FRAME_BITS-2:0], sdi_q};
        if (bitcnt != CNT_SAT) bitcnt <= bitcnt + 1'b1;
      end
      if (cs_rise) begin
        bitcnt <= '0;
        if (frame_ok) begin
          wr_stb  <= 1'b1;
          wr_addr <= shreg[DW +: AW];
          wr_data <= shreg[DW-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/regport_tw.sv
module regport_tw
  import regport_pkg::*;
#(
  parameter int unsigned AW   = ADDR_WIDTH,
  parameter int unsigned DW   = REG_WIDTH,
  parameter int unsigned NREG = REG_COUNT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          addr_pin,
  input  logic          scl_q,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_q,
  input  logic          sda_rise,
  input  logic          sda_fall,
  output logic          ack_on,
  output logic          start_evt,
  output logic          stop_evt,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  tw_state_e     state;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr;
  logic          byte_done;
  logic          ack_done;

  assign start_evt = en && scl_q && sda_fall;
  assign stop_evt  = en && scl_q && sda_rise;
  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign ack_done  = scl_fall && (bitcnt == 4'd9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TW_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      ack_on  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (!en) begin
      state  <= TW_IDLE;
      bitcnt <= '0;
      ack_on <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        state  <= TW_ADDR;
        bitcnt <= '0;
        ack_on <= 1'b0;
      end else if (stop_evt) begin
        state  <= TW_IDLE;
        bitcnt <= '0;
        ack_on <= 1'b0;
      end else if (state != TW_IDLE) begin
        if (scl_rise && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_q};
          bitcnt <= bitcnt + 1'b1;
        end else if (byte_done) begin
          bitcnt <= 4'd9;
          case (state)
            TW_ADDR: begin
              if (dev_match(shreg, addr_pin)) begin
                ack_on <= 1'b1;
                state  <= TW_PTR;
              end else begin
                state <= TW_SKIP;
              end
            end
            TW_PTR: begin
              if (shreg[7:AW] == '0) begin
                ack_on <= 1'b1;
                ptr    <= shreg[AW-1:0];
                state  <= TW_DATA;
              end else begin
                state <= TW_SKIP;
              end
            end
            TW_DATA: begin
              ack_on  <= 1'b1;
              wr_stb  <= 1'b1;
              wr_addr <= ptr;
              wr_data <= shreg;
              ptr     <= ptr_next(ptr, NREG);
            end
            default: ;
          endcase
        end else if (ack_done) begin
          bitcnt <= '0;
          ack_on <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/regport_bank.sv
module regport_bank
  import regport_pkg::*;
#(
  parameter int unsigned NREG = REG_COUNT,
  parameter int unsigned AW   = ADDR_WIDTH,
  parameter int unsigned DW   = REG_WIDTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic               init_hit,
  output logic [NREG*DW-1:0] regs
);

  assign init_hit = wr_stb && (32'(wr_addr) == INIT_REG) && wr_data[INIT_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i*DW +: DW] <= reg_default(i);
      end else if (init_hit) begin
        regs[i*DW +: DW] <= reg_default(i);
      end else if (wr_stb && 32'(wr_addr) == i) begin
        regs[i*DW +: DW] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/regport_top.sv
module regport_top
  import regport_pkg::*;
#(
  parameter int unsigned NREG        = REG_COUNT,
  parameter int unsigned AW          = ADDR_WIDTH,
  parameter int unsigned DW          = REG_WIDTH,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_tw,
  input  logic               addr_pin,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               sdi,
  input  logic               scl,
  input  logic               sda_in,
  output logic               sda_pull_low,
  output logic [NREG*DW-1:0] regs_o
);

  localparam int unsigned LINES = 5;
  localparam int unsigned L_CS = 0, L_SCK = 1, L_SDI = 2, L_SCL = 3, L_SDA = 4;

  logic [LINES-1:0] line_q, line_rise, line_fall;
  logic             scl_s;
  logic             sw_stb, tw_stb, wr_stb, init_hit, tw_ack;
  logic             start_evt, stop_evt;
  logic [AW-1:0]    sw_addr, tw_addr, wr_addr;
  logic [DW-1:0]    sw_data, tw_data, wr_data;

  regport_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(5'b11111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sda_in, scl, sdi, sck, cs_n}),
    .q    (line_q),
    .rise (line_rise),
    .fall (line_fall)
  );

  assign scl_s = line_q[L_SCL];

  regport_sw3 #(.AW(AW), .DW(DW)) u_sw3 (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (!mode_tw),
    .cs_q    (line_q[L_CS]),
    .cs_rise (line_rise[L_CS]),
    .cs_fall (line_fall[L_CS]),
    .sck_rise(line_rise[L_SCK]),
    .sdi_q   (line_q[L_SDI]),
    .wr_stb  (sw_stb),
    .wr_addr (sw_addr),
    .wr_data (sw_data)
  );

  regport_tw #(.AW(AW), .DW(DW), .NREG(NREG)) u_tw (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (mode_tw),
    .addr_pin (addr_pin),
    .scl_q    (scl_s),
    .scl_rise (line_rise[L_SCL]),
    .scl_fall (line_fall[L_SCL]),
    .sda_q    (line_q[L_SDA]),
    .sda_rise (line_rise[L_SDA]),
    .sda_fall (line_fall[L_SDA]),
    .ack_on   (tw_ack),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .wr_stb   (tw_stb),
    .wr_addr  (tw_addr),
    .wr_data  (tw_data)
  );

  assign wr_stb  = sw_stb | tw_stb;
  assign wr_addr = tw_stb ? tw_addr : sw_addr;
  assign wr_data = tw_stb ? tw_data : sw_data;

  regport_bank #(.NREG(NREG), .AW(AW), .DW(DW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .init_hit(init_hit),
    .regs    (regs_o)
  );

  assign sda_pull_low = tw_ack;

endmodule

// File: rtl/regport_chk.sv
module regport_chk
  import regport_pkg::*;
#(
  parameter int unsigned NREG = REG_COUNT,
  parameter int unsigned AW   = ADDR_WIDTH,
  parameter int unsigned DW   = REG_WIDTH
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_tw,
  input logic               scl_s,
  input logic               sda_pull_low,
  input logic               sw_stb,
  input logic               tw_stb,
  input logic               wr_stb,
  input logic [AW-1:0]      wr_addr,
  input logic [DW-1:0]      wr_data,
  input logic               init_hit,
  input logic [NREG*DW-1:0] regs_o
);

  function automatic logic [NREG*DW-1:0] all_defaults();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = reg_default(i);
    return v;
  endfunction

  logic          pend;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      pend      <= wr_stb && (32'(wr_addr) < NREG) && !init_hit;
      pend_addr <= wr_addr;
      pend_data <= wr_data;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> regs_o[32'(pend_addr)*DW +: DW] == pend_data); // R2

  AST_HIGH_ADDR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && (32'(wr_addr) >= NREG) |=> regs_o == $past(regs_o)); // R7

  AST_INIT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    init_hit |=> regs_o == all_defaults()); // R8

  AST_ONE_PORT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_stb, tw_stb})); // R10

  AST_NO_PULL_IN_3W: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_tw && !$past(mode_tw) |-> !sda_pull_low); // R10

  AST_NO_3W_IN_TW: assert property (@(posedge clk) disable iff (!rst_n)
    mode_tw && $past(mode_tw) |-> !sw_stb); // R10

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_low != $past(sda_pull_low)) |-> !scl_s); // R11

endmodule

bind regport_top regport_chk #(.NREG(NREG), .AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_tw     (mode_tw),
  .scl_s       (scl_s),
  .sda_pull_low(sda_pull_low),
  .sw_stb      (sw_stb),
  .tw_stb      (tw_stb),
  .wr_stb      (wr_stb),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .init_hit    (init_hit),
  .regs_o      (regs_o)
);

// File: tb/regport_top_test.sv
module regport_top_test;

  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic mode_tw = 1'b0, addr_pin = 1'b1, cs_n = 1'b1, sck = 1'b1, sdi = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  wire        sda_pull_low;
  wire [31:0] regs_o;
  wire        sda_line = sda_m & ~sda_pull_low;

  regport_top uut (
    .clk(clk), .rst_n(rst_n), .mode_tw(mode_tw), .addr_pin(addr_pin),
    .cs_n(cs_n), .sck(sck), .sdi(sdi), .scl(scl), .sda_in(sda_line),
    .sda_pull_low(sda_pull_low), .regs_o(regs_o)
  );

  int  checks = 0, failures = 0, viol = 0;
  bit  done = 0;
  logic [7:0] m [4];
  logic [7:0] tb_buf [8];

  function automatic logic [7:0] dflt(input int i);
    case (i)
      0: return 8'h89;
      1: return 8'h02;
      2: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [4:0] step(input logic [4:0] p);
    return (p == 5'd3) ? 5'd0 : p + 5'd1;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 4; i++) m[i] = dflt(i);
  endtask

  task automatic m_write(input logic [4:0] a, input logic [7:0] d);
    if (a == 5'd1 && d[7]) m_reset();
    else if (a < 5'd4) m[a[1:0]] = d;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    logic [31:0] exp;
    exp = {m[3], m[2], m[1], m[0]};
    chk(regs_o == exp, req, regs_o, exp);
  endtask

  // 3-wire: first nbits of f, MSB first.
  task automatic sw_frame(input logic [15:0] f, input int nbits, input string req);
    cs_n = 1'b0;
    tick(Q);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      sdi = f[15-i];
      tick(2*Q);
      sck = 1'b1;
      tick(2*Q);
    end
    tick(Q);
    cs_n = 1'b1;
    if (nbits == 16 && f[15:13] == 3'b111 && !mode_tw) m_write(f[12:8], f[7:0]);
    tick(8);
    check_regs(req);
  endtask

  task automatic tw_start();
    tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q); scl = 1'b0;
  endtask

  task automatic tw_stop();
    tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b1; tick(2*Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic tw_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    end
    tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = sda_pull_low;
    tick(Q); scl = 1'b0;
  endtask

  // Full write burst from tb_buf; checks every acknowledge and the registers.
  task automatic tw_write(input logic [7:0] dev, input logic [7:0] ptr, input int n,
                          input string req);
    logic ack;
    bit   dev_ok, ptr_ok;
    logic [4:0] p;
    dev_ok = mode_tw && dev[7:1] == {6'b001001, addr_pin} && !dev[0];
    ptr_ok = dev_ok && ptr[7:5] == 3'b000;
    tw_start();
    tw_byte(dev, ack);
    chk(ack == dev_ok, req, 32'(ack), 32'(dev_ok));
    tw_byte(ptr, ack);
    chk(ack == ptr_ok, req, 32'(ack), 32'(ptr_ok));
    p = ptr[4:0];
    for (int i = 0; i < n; i++) begin
      tw_byte(tb_buf[i], ack);
      chk(ack == ptr_ok, req, 32'(ack), 32'(ptr_ok));
      if (ptr_ok) begin
        m_write(p, tb_buf[i]);
        p = step(p);
      end
    end
    tw_stop();
    tick(8);
    check_regs(req);
  endtask

  // R11: the acknowledge may only move while SCL is low.
  always @(sda_pull_low) if (rst_n && scl) viol++;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    void'($urandom(32'h5EED1234));
    m_reset();
    tick(5);
    rst_n = 1'b1;
    tick(3);
    check_regs("R1 reset defaults");

    // 3-wire directed
    sw_frame({3'b111, 5'h00, 8'hA5}, 16, "R2 3-wire write reg0");
    sw_frame({3'b111, 5'h03, 8'h3C}, 16, "R2 3-wire write reg3");
    sw_frame({3'b101, 5'h02, 8'hFF}, 16, "R3 bad chip code");
    sw_frame({3'b110, 5'h02, 8'hFF}, 16, "R3 write flag zero");
    sw_frame({3'b111, 5'h02, 8'h55}, 15, "R3 short frame");
    sw_frame({3'b111, 5'h05, 8'h77}, 16, "R7 3-wire high address");
    sw_frame({3'b111, 5'h01, 8'h80}, 16, "R8 3-wire init bit");

    // 3-wire random
    for (int k = 0; k < 30; k++) begin
      logic [2:0] hdr;
      hdr = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b111;
      sw_frame({hdr, 5'($urandom_range(0, 7)), 8'($urandom)}, 16, "R2 random 3-wire");
    end

    // Two-wire port ignored in 3-wire mode
    tb_buf[0] = 8'h5A;
    tw_write(8'h26, 8'h00, 1, "R10 two-wire in 3-wire mode");

    mode_tw = 1'b1;
    tick(8);
    sw_frame({3'b111, 5'h00, 8'h11}, 16, "R10 3-wire in two-wire mode");

    // Two-wire directed
    tb_buf[0] = 8'h11; tb_buf[1] = 8'h22; tb_buf[2] = 8'h33;
    tb_buf[3] = 8'h44; tb_buf[4] = 8'h55;
    tw_write(8'h26, 8'h02, 5, "R6 burst wraps 03h to 00h");
    tb_buf[0] = 8'h99;
    tw_write(8'h24, 8'h00, 1, "R4 wrong device address");
    tw_write(8'h27, 8'h00, 1, "R4 read direction");
    tw_write(8'h26, 8'h20, 1, "R5 pointer top bits set");
    tb_buf[0] = 8'hE1; tb_buf[1] = 8'hE2; tb_buf[2] = 8'h6B;
    tw_write(8'h26, 8'h1E, 3, "R7 high pointer then 1Fh wrap");
    tb_buf[0] = 8'hC0;
    tw_write(8'h26, 8'h01, 1, "R8 two-wire init bit");
    addr_pin = 1'b0;
    tb_buf[0] = 8'h4D;
    tw_write(8'h24, 8'h02, 1, "R4 address pin low");
    addr_pin = 1'b1;

    // R9: repeated START, then bytes after STOP are ignored
    tw_start();
    tw_byte(8'h26, ack); tw_byte(8'h00, ack); tw_byte(8'h61, ack);
    m_write(5'd0, 8'h61);
    tw_start();
    tw_byte(8'h26, ack);
    chk(ack == 1'b1, "R9 repeated START address ack", 32'(ack), 32'd1);
    tw_byte(8'h03, ack); tw_byte(8'h62, ack);
    m_write(5'd3, 8'h62);
    tw_stop();
    tick(8);
    check_regs("R9 repeated START writes");
    tick(Q); scl = 1'b0;
    tw_byte(8'h26, ack);
    chk(ack == 1'b0, "R9 no ack after STOP", 32'(ack), 32'd0);
    tw_byte(8'h00, ack); tw_byte(8'h00, ack);
    tick(Q); scl = 1'b1; tick(8);
    check_regs("R9 bytes after STOP ignored");

    // Two-wire random
    for (int k = 0; k < 16; k++) begin
      int n;
      logic [7:0] dev, ptr;
      n   = $urandom_range(1, 6);
      dev = ($urandom_range(0, 5) == 0) ? 8'h2E : 8'h26;
      ptr = ($urandom_range(0, 7) == 0) ? 8'h1E : 8'($urandom_range(0, 6));
      for (int i = 0; i < n; i++) tb_buf[i] = 8'($urandom);
      tw_write(dev, ptr, n, "R6 random burst");
    end

    chk(viol == 0, "R11 sda pull changed while SCL high", 32'(viol), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule